// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models a serial EEPROM as seen from its three-wire bus: a chip select, a serial clock, a data input and a data output. It contains a 256 x 16-bit word array. A host selects the block, clocks in a framed instruction, and either reads words back or starts a programming operation. The three bus inputs come from a slower domain. They pass through two-flop synchronisers into the system clock, and serial clock rising edges are detected there.

A frame opens with a start bit of 1. Two opcode bits follow, then eight address bits, and for the two writing commands sixteen data bits. Reads stream words for as long as select stays high. The commands that change the array run a self-timed programming cycle. It is modelled as `PROG_CYCLES` system clocks. A write-enable latch gates every such command. During and after the cycle, a fresh select pulse turns the data output into a ready/busy flag. The output is driven only when an enable says so. The enable is low whenever select is low or nothing is being reported.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, `do_oe` is 0 and the write-enable latch is cleared, so array-changing commands are ignored until enabled again. The array contents are not touched by reset.
- R2: Serial clock edges that sample a 0 while no frame is open are ignored, and the first 1 opens the frame.
- R3: READ (opcode bits 10, sent first bit first) drives a 0 dummy bit once the last address bit is sampled. The 16 data bits follow, MSB first, and each one appears after a serial clock rising edge.
- R4: While select stays high after a word has been read, the address increments and the next word follows at once with no dummy bit. Address 255 wraps to 0.
- R5: Opcode 00 with the top two address bits 11 sets the write-enable latch, and with 00 clears it. The other six address bits are don't-care but must still be clocked in. WRITE, ERASE, erase-all and write-all have no effect while the latch is clear.
- R6: WRITE (opcode 01) stores the 16 data bits that follow the address, MSB first.
- R7: ERASE (opcode 11) sets all bits of the addressed word to 1.
- R8: Opcode 00 with top address bits 10 sets every word to all ones (erase-all). With top address bits 01 it stores the following 16 data bits in every word (write-all).
- R9: After select has gone low and then high while a programming cycle runs, `do_oe` is 1 and `do_o` is 0 until the cycle ends. `do_o` is 1 afterwards while select stays high.
- R10: If select rises after the programming cycle has ended, no ready/busy status is driven (`do_oe` stays 0).
- R11: Frames sent while a programming cycle runs are ignored. This includes a disable command.
- R12: A frame cut short by select going low leaves the array unchanged.
- R13: `do_oe` is 0 whenever the synchronised select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select from the bus, active high |
| sk | input | 1 | Serial clock from the bus |
| di | input | 1 | Serial data into the block |
| do_o | output | 1 | Serial data or ready/busy flag out |
| do_oe | output | 1 | Output enable for `do_o` (pad tri-stated when 0) |

## Verification
The end of the self-timed programming cycle can fall in the same system clock as the detection of a rising select. In that case the block must either stay silent or report ready, and must never report busy after the cycle has ended. The bench provokes this by sweeping the delay between the end of a WRITE frame and the next select rise across the programming window in small steps. After the window has surely closed, it accepts only an undriven output or a driven 1.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int AW          = 8,
  parameter int DW          = 16,
  parameter int PROG_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic do_o,
  output logic do_oe
);
  localparam int WORDS = 1 << AW;
  localparam int HW    = AW + 2;
  localparam int CNTW  = $clog2(HW + DW + 1);
  localparam int BW    = $clog2(DW);
  localparam int CW    = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_HDR, S_DATA, S_RD, S_SKIP} st_t;

  logic [DW-1:0] mem [WORDS];

  logic cs_m, cs_s, cs_d, sk_m, sk_s, sk_d, di_m, di_s;
  st_t            st;
  logic [CNTW-1:0] cnt;
  logic [BW-1:0]  bi;
  logic [HW-2:0]  sr;
  logic [DW-2:0]  wsh;
  logic [DW-1:0]  rsh;
  logic [AW-1:0]  ptr;
  logic           all_sel;
  logic           we, rb_mode, dout;
  logic [CW-1:0]  bcnt;
  logic           prog_one, prog_all;
  logic [AW-1:0]  prog_addr;
  logic [DW-1:0]  prog_data;

  wire cs_rise = cs_s & ~cs_d;
  wire sk_rise = sk_s & ~sk_d;
  wire busy    = (bcnt != '0);
  wire [HW-1:0] hdr = {sr, di_s};
  wire [1:0]    op  = hdr[HW-1:HW-2];
  wire [AW-1:0] ad  = hdr[AW-1:0];
  wire [1:0]    sub = hdr[AW-1:AW-2];

  assign do_oe = cs_s & (rb_mode | (st == S_RD));
  assign do_o  = rb_mode ? ~busy : dout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_m, cs_s, cs_d, sk_m, sk_s, sk_d, di_m, di_s} <= '0;
      st        <= S_IDLE;
      cnt       <= '0;
      bi        <= '0;
      sr        <= '0;
      wsh       <= '0;
      rsh       <= '0;
      ptr       <= '0;
      all_sel   <= 1'b0;
      we        <= 1'b0;
      rb_mode   <= 1'b0;
      dout      <= 1'b0;
      bcnt      <= '0;
      prog_one  <= 1'b0;
      prog_all  <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
    end else begin
      cs_m <= cs; cs_s <= cs_m; cs_d <= cs_s;
      sk_m <= sk; sk_s <= sk_m; sk_d <= sk_s;
      di_m <= di; di_s <= di_m;
      prog_one <= 1'b0;
      prog_all <= 1'b0;
      if (busy) bcnt <= bcnt - 1'b1;

      if (!cs_s) begin
        st      <= S_IDLE;
        rb_mode <= 1'b0;
      end else if (cs_rise) begin
        st      <= S_IDLE;
        rb_mode <= busy;
      end else if (sk_rise) begin
        case (st)
          S_IDLE: if (!busy && di_s) begin
            st      <= S_HDR;
            cnt     <= '0;
            rb_mode <= 1'b0;
          end
          S_HDR: begin
            sr  <= {sr[HW-3:0], di_s};
            cnt <= cnt + 1'b1;
            if (cnt == CNTW'(HW - 1)) begin
              st <= S_SKIP;
              case (op)
                2'b10: begin
                  rsh  <= mem[ad];
                  ptr  <= ad;
                  dout <= 1'b0;
                  bi   <= '0;
                  st   <= S_RD;
                end
                2'b01: begin
                  ptr     <= ad;
                  cnt     <= '0;
                  all_sel <= 1'b0;
                  if (we) st <= S_DATA;
                end
                2'b11: if (we) begin
                  prog_one  <= 1'b1;
                  prog_addr <= ad;
                  prog_data <= '1;
                  bcnt      <= CW'(PROG_CYCLES);
                end
                default: case (sub)
                  2'b11: we <= 1'b1;
                  2'b00: we <= 1'b0;
                  2'b10: if (we) begin
                    prog_all  <= 1'b1;
                    prog_data <= '1;
                    bcnt      <= CW'(PROG_CYCLES);
                  end
                  default: begin
                    cnt     <= '0;
                    all_sel <= 1'b1;
                    if (we) st <= S_DATA;
                  end
                endcase
              endcase
            end
          end
          S_DATA: begin
            wsh <= {wsh[DW-3:0], di_s};
            cnt <= cnt + 1'b1;
            if (cnt == CNTW'(DW - 1)) begin
              prog_one  <= ~all_sel;
              prog_all  <= all_sel;
              prog_addr <= ptr;
              prog_data <= {wsh, di_s};
              bcnt      <= CW'(PROG_CYCLES);
              st        <= S_SKIP;
            end
          end
          S_RD: begin
            dout <= rsh[DW-1];
            if (bi == BW'(DW - 1)) begin
              bi  <= '0;
              ptr <= ptr + 1'b1;
              rsh <= mem[ptr + 1'b1];
            end else begin
              bi  <= bi + 1'b1;
              rsh <= {rsh[DW-2:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WORDS; i++)
      if (prog_all || (prog_one && prog_addr == AW'(i)))
        mem[i] <= prog_data;
  end
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_s,
  input logic cs_rise,
  input logic busy,
  input logic we,
  input logic rb_mode,
  input logic do_o,
  input logic do_oe
);
  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    do_oe |-> cs_s); // R13
  AST_PROG_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(we)); // R5
  AST_WE_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(we)); // R11
  AST_SILENT_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise && !busy |=> !do_oe); // R10
  AST_READY_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && rb_mode && cs_s |-> do_o); // R9
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_rise(cs_rise), .busy(busy),
  .we(we), .rb_mode(rb_mode), .do_o(do_o), .do_oe(do_oe)
);

// File: tb/mw_eeprom_bench.sv
module mw_eeprom_bench;
  localparam int PROG = 1000;
  localparam int H    = 8;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  logic do_o, do_oe;
  int   errors = 0, checks = 0;
  logic [15:0] model [256];

  always #2 clk = ~clk;

  mw_eeprom #(.AW(8), .DW(16), .PROG_CYCLES(PROG)) u_mw_eeprom (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .do_o(do_o), .do_oe(do_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_in(input logic b);
    @(negedge clk); sk = 1'b0; di = b;
    wait_clk(H); sk = 1'b1;
    wait_clk(H);
  endtask

  task automatic cs_on();
    @(negedge clk); sk = 1'b0; cs = 1'b1; wait_clk(6);
  endtask

  task automatic cs_off();
    @(negedge clk); sk = 1'b0; cs = 1'b0; wait_clk(6);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [7:0] a);
    bit_in(1'b1); bit_in(op[1]); bit_in(op[0]);
    for (int i = 7; i >= 0; i--) bit_in(a[i]);
  endtask

  task automatic data16(input logic [15:0] d);
    for (int i = 15; i >= 0; i--) bit_in(d[i]);
  endtask

  task automatic cmd(input logic [7:0] a);
    cs_on(); hdr(2'b00, a); cs_off();
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    cs_on(); hdr(2'b01, a); data16(d); cs_off(); wait_clk(PROG + 20);
  endtask

  task automatic er(input logic [7:0] a);
    cs_on(); hdr(2'b11, a); cs_off(); wait_clk(PROG + 20);
  endtask

  task automatic eral();
    cmd(8'h80); wait_clk(PROG + 20);
    for (int i = 0; i < 256; i++) model[i] = 16'hFFFF;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input int n);
    logic [15:0] got;
    cs_on(); hdr(2'b10, a);
    check({req, " dummy"}, {30'd0, do_oe, do_o}, 32'd2);
    for (int w = 0; w < n; w++) begin
      for (int b = 15; b >= 0; b--) begin
        bit_in(1'b0);
        got[b] = do_o;
      end
      check(req, {16'd0, got}, {16'd0, model[8'(a + w)]});
    end
    cs_off();
  endtask

  initial begin
    logic [7:0]  a;
    logic [15:0] d;
    void'($urandom(32'd20240611));
    wait_clk(5);
    check("R1 oe after reset", {31'd0, do_oe}, 32'd0);
    rst_n = 1'b1;
    wait_clk(5);
    check("R13 idle oe", {31'd0, do_oe}, 32'd0);

    cmd(8'hC0); eral(); cmd(8'h00);
    wr(8'h05, 16'h1234);
    rd("R5 write while disabled", 8'h05, 1);
    cmd(8'hC0);
    @(negedge clk); rst_n = 1'b0; wait_clk(3); rst_n = 1'b1; wait_clk(3);
    wr(8'h06, 16'h4321);
    rd("R1 latch cleared by reset", 8'h06, 1);

    cmd(8'hC5);
    wr(8'h10, 16'hA5C3); model[8'h10] = 16'hA5C3;
    rd("R6 write", 8'h10, 1);
    er(8'h10); model[8'h10] = 16'hFFFF;
    rd("R7 erase", 8'h10, 1);

    cs_on(); bit_in(0); bit_in(0); bit_in(0); hdr(2'b01, 8'h20); data16(16'h0F0F);
    cs_off(); wait_clk(PROG + 20); model[8'h20] = 16'h0F0F;
    rd("R2 leading zeros", 8'h20, 1);

    wr(8'hFE, 16'h1111); model[8'hFE] = 16'h1111;
    wr(8'hFF, 16'h8002); model[8'hFF] = 16'h8002;
    wr(8'h00, 16'h7FFE); model[8'h00] = 16'h7FFE;
    rd("R4 sequential wrap", 8'hFE, 3);
    rd("R3 single read", 8'h00, 1);

    cs_on(); hdr(2'b01, 8'h30); for (int i = 0; i < 8; i++) bit_in(1'b0); cs_off();
    wait_clk(PROG + 20);
    rd("R12 aborted frame", 8'h30, 1);

    cs_on(); hdr(2'b01, 8'h31); data16(16'hBEEF); cs_off(); model[8'h31] = 16'hBEEF;
    cs_on();
    check("R9 busy", {30'd0, do_oe, do_o}, 32'd2);
    wait_clk(PROG);
    check("R9 ready", {30'd0, do_oe, do_o}, 32'd3);
    cs_off();
    check("R13 oe after cs low", {31'd0, do_oe}, 32'd0);

    cs_on(); hdr(2'b01, 8'h32); data16(16'h1357); cs_off(); model[8'h32] = 16'h1357;
    wait_clk(PROG + 20);
    cs_on();
    check("R10 no status", {31'd0, do_oe}, 32'd0);
    cs_off();

    cs_on(); hdr(2'b01, 8'h40); data16(16'h2468); cs_off(); model[8'h40] = 16'h2468;
    cmd(8'h00);
    wait_clk(PROG + 20);
    wr(8'h41, 16'h9753); model[8'h41] = 16'h9753;
    rd("R11 disable ignored while busy", 8'h41, 1);
    rd("R11 earlier write", 8'h40, 1);

    for (int k = PROG - 40; k <= PROG + 10; k += 3) begin
      cs_on(); hdr(2'b01, 8'h50); data16(16'(k)); cs_off(); model[8'h50] = 16'(k);
      wait_clk(k);
      cs_on(); wait_clk(PROG);
      check("R9 R10 edge sweep", {31'd0, do_oe && !do_o}, 32'd0);
      cs_off();
    end

    cs_on(); hdr(2'b00, 8'h40); data16(16'h5A5A); cs_off(); wait_clk(PROG + 20);
    for (int i = 0; i < 256; i++) model[i] = 16'h5A5A;
    rd("R8 write-all", 8'h00, 1);
    rd("R8 write-all", 8'hC3, 1);
    eral();
    rd("R8 erase-all", 8'h77, 2);

    for (int n = 0; n < 10; n++) begin
      a = 8'($urandom); d = 16'($urandom);
      wr(a, d); model[a] = d;
      rd("R6 R4 random", a, 2);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule